// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block resolves a single instruction operand per request. The caller presents a 3-bit addressing mode, a 4-bit unsigned operand field and a direction bit. For a read, the block returns the effective value. For a write, it places the supplied value at the effective location. The block holds a sixteen-entry register file and a sixteen-entry hardware operand stack. It also drives a simple synchronous memory port, and it applies every side effect of the mode: register increments and decrements, and stack pushes and pops. Register 2 stands for the operand stack throughout. When an instruction has several operands, the caller issues one request per operand, inputs first in op0, op1, op2 order and then outputs. Each request's side effects take effect when the request is accepted, so requests see each other's effects in issue order. This holds even for conditional instructions whose condition later turns out false.

In the two address-arithmetic modes, base field 0 selects the program counter input in place of the zero register. A write in immediate mode does not touch any storage. It emits a one-cycle device strobe that carries the operand field as a device number, together with the value.

Top module: `operand_resolver`

## Requirements
- R1: After a synchronous active-high reset, busy, done, dev_stb, mem_req and stk_err are 0, every register reads 0 and the operand stack is empty.
- R2: Mode 0 (immediate) read returns the operand field zero-extended. Mode 0 write makes no memory access and raises dev_stb for one cycle, in the same cycle as done, with dev_sel equal to the operand field and dev_data equal to the value.
- R3: Mode 1 (register direct) reads or writes register N. Register 0 reads as zero and ignores writes. For N = 2, a read pops the stack and returns the popped word, and a write pushes the value.
- R4: Mode 2 (register indirect) reads or writes memory at the address held in register N. For N = 2, the address is popped from the stack.
- R5: Mode 3 (stack slot) reads or overwrites stack entry k counted from the top (k = 0 is the top) without changing the depth. A k at or beyond the current depth is a stack error.
- R6: Mode 4 (constant) uses table entry k = 0x0100 + 16*k. A read returns the entry. A write stores the value to memory at that entry.
- R7: Mode 5 (displacement) forms address = base + displacement. The base field is operand[3:2] and the displacement field is operand[1:0]. Field value 2 pops the stack, with the displacement popped before the base. A base field of 0 selects the pc input, and a displacement field of 0 reads the zero register.
- R8: Mode 6 (indexed) forms address = base + index. The base field is operand[3:2], the same as in R7, and the index register is operand[1:0] + 2. An index register of 2 pops the stack before the base.
- R9: Mode 7 (predecrement/postincrement) read fetches memory at register N and then adds 1 to N. A write first subtracts 1 from N and then stores at the new value. For N = 2, a read pops and a write pushes. Register 0 stays zero.
- R10: A pop from an empty stack, a push onto a full one, or an out-of-range slot access sets stk_err, which stays set until reset. The request then completes with no stack, register, memory or device effect, and a read returns 0.
- R11: A request is accepted only while busy is low. The request completes in 1 cycle with no memory access, in 2 cycles with a memory write, and in 3 cycles with a memory read with one-cycle latency. mem_req is a one-cycle pulse issued the cycle after acceptance, and busy is high until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand request present |
| req_write | input | 1 | 1 = place req_wdata, 0 = fetch value |
| req_mode | input | 3 | Addressing mode 0..7 |
| req_opnd | input | 4 | Unsigned operand field |
| req_wdata | input | 16 | Value to place on a write |
| pc | input | 16 | Current program counter |
| busy | output | 1 | Memory access in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_value | output | 16 | Effective value of the last read |
| stk_err | output | 1 | Sticky stack error |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_rvalid | input | 1 | Read data valid pulse |
| dev_stb | output | 1 | Immediate-mode output strobe |
| dev_sel | output | 4 | Device number |
| dev_data | output | 16 | Device value |

## Verification
The bench targets operand combinations where both fields pop the stack. A resolver that popped in the wrong order, or popped only once, would swap base and offset or leave a stray word on the stack, and a later pop would expose it. It checks that base field 0 uses the pc, so a design that read register 0 would hit the wrong address. It checks that predecrement writes land at the decremented address, so a postdecrement design would leave the word one location high. It drives pushes past a full stack and pops from an empty one. A design that wrapped its pointer, or let the faulting request touch memory, would corrupt the top entry or the memory contents. Completion latency is measured on every request, which catches a read that completes before its data arrives.

// File: rtl/opres_pkg.sv
package opres_pkg;

    localparam int WORD_W = 16;
    localparam int OPND_W = 4;
    localparam int NREG   = 1 << OPND_W;

    typedef enum logic [2:0] {
        AM_IMM   = 3'd0,
        AM_REG   = 3'd1,
        AM_RIND  = 3'd2,
        AM_STK   = 3'd3,
        AM_CONST = 3'd4,
        AM_DISP  = 3'd5,
        AM_IDX   = 3'd6,
        AM_PPI   = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RD,
        PH_WR
    } phase_e;

    // Resolved action for one operand request
    typedef struct packed {
        logic [1:0]        pop_n;
        logic              push;
        logic              slot_en;
        logic              slot_we;
        logic              reg_we;
        logic [OPND_W-1:0] reg_idx;
        logic [WORD_W-1:0] reg_val;
        logic              mem_go;
        logic              mem_wr;
        logic [WORD_W-1:0] mem_a;
        logic [WORD_W-1:0] val;
        logic              dev_go;
    } plan_t;

    function automatic logic [WORD_W-1:0] const_entry(input logic [OPND_W-1:0] k);
        return WORD_W'(16'h0100) + (WORD_W'(k) << 4);
    endfunction

endpackage

// File: rtl/opres_regfile.sv
module opres_regfile
    import opres_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [OPND_W-1:0] widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [OPND_W-1:0] ra_idx,
    input  logic [OPND_W-1:0] rb_idx,
    input  logic [OPND_W-1:0] rc_idx,
    output logic [WORD_W-1:0] ra,
    output logic [WORD_W-1:0] rb,
    output logic [WORD_W-1:0] rc
);

    logic [WORD_W-1:0] rv [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0 || g == 2) begin : g_tied
            // zero register, and the stack alias slot
            assign rv[g] = '0;
        end else begin : g_store
            logic [WORD_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)                                q <= '0;
                else if (we && widx == OPND_W'(g))      q <= wdata;
            end
            assign rv[g] = q;
        end
    end

    assign ra = rv[ra_idx];
    assign rb = rv[rb_idx];
    assign rc = rv[rc_idx];

endmodule

// File: rtl/opres_stack.sv
module opres_stack
    import opres_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pop_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              slot_en,
    input  logic              slot_we,
    input  logic [OPND_W-1:0] slot_idx,
    output logic [WORD_W-1:0] top0,
    output logic [WORD_W-1:0] top1,
    output logic [WORD_W-1:0] slot_rdata,
    output logic              legal,
    output logic              err
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [WORD_W-1:0] ent [DEPTH];
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     pos;

    assign pos        = cnt - CW'(1) - CW'(slot_idx);
    assign top0       = (cnt > CW'(0)) ? ent[IW'(cnt - CW'(1))] : '0;
    assign top1       = (cnt > CW'(1)) ? ent[IW'(cnt - CW'(2))] : '0;
    assign slot_rdata = (CW'(slot_idx) < cnt) ? ent[pos[IW-1:0]] : '0;

    assign legal = !(CW'(pop_n) > cnt)
                && !(push && cnt == FULL)
                && !(slot_en && CW'(slot_idx) >= cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            err <= 1'b0;
        end else if (!legal) begin
            err <= 1'b1;
        end else if (push) begin
            ent[cnt[IW-1:0]] <= push_data;
            cnt              <= cnt + CW'(1);
        end else if (pop_n != 2'd0) begin
            cnt <= cnt - CW'(pop_n);
        end else if (slot_en && slot_we) begin
            ent[pos[IW-1:0]] <= push_data;
        end
    end

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err |=> err);

    // R10
    bad_op_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !legal |=> $stable(cnt));

    // R5
    slot_depth_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_en && legal && !push && pop_n == 2'd0) |=> $stable(cnt));

endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
    import opres_pkg::*;
#(
    parameter int STACK_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_mode,
    input  logic [OPND_W-1:0] req_opnd,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [WORD_W-1:0] pc,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_value,
    output logic              stk_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              dev_stb,
    output logic [OPND_W-1:0] dev_sel,
    output logic [WORD_W-1:0] dev_data
);

    localparam int W = WORD_W;

    phase_e            phase;
    amode_e            mode;
    plan_t             pl;
    logic              fire, stk_ok, is_two, sec_pop, base_pop;
    logic [OPND_W-1:0] sec_idx;
    logic [W-1:0]      ra, rb, rc, top0, top1, slot_rd, sec_v, base_v;

    assign mode   = amode_e'(req_mode);
    assign fire   = req_valid && (phase == PH_IDLE);
    assign busy   = (phase != PH_IDLE);
    assign is_two = (req_opnd == OPND_W'(2));

    // second address field: displacement register or index register (+2)
    assign sec_pop  = (mode == AM_IDX) ? (req_opnd[1:0] == 2'd0) : (req_opnd[1:0] == 2'd2);
    assign base_pop = (req_opnd[3:2] == 2'd2);
    assign sec_idx  = (mode == AM_IDX) ? (OPND_W'(req_opnd[1:0]) + OPND_W'(2))
                                       : OPND_W'(req_opnd[1:0]);
    assign sec_v    = sec_pop ? top0 : rc;
    assign base_v   = base_pop ? (sec_pop ? top1 : top0)
                               : ((req_opnd[3:2] == 2'd0) ? pc : rb);

    always_comb begin
        pl = '0;
        unique case (mode)
            AM_IMM: begin
                if (req_write) pl.dev_go = 1'b1;
                else           pl.val    = W'(req_opnd);
            end
            AM_REG, AM_PPI: begin
                if (is_two) begin
                    if (req_write) pl.push = 1'b1;
                    else begin
                        pl.pop_n = 2'd1;
                        pl.val   = top0;
                    end
                end else if (mode == AM_REG) begin
                    if (req_write) begin
                        pl.reg_we  = 1'b1;
                        pl.reg_idx = req_opnd;
                        pl.reg_val = req_wdata;
                    end else begin
                        pl.val = ra;
                    end
                end else begin
                    pl.reg_we  = 1'b1;
                    pl.reg_idx = req_opnd;
                    pl.mem_go  = 1'b1;
                    pl.mem_wr  = req_write;
                    if (req_write) begin
                        pl.reg_val = ra - W'(1);
                        pl.mem_a   = ra - W'(1);
                    end else begin
                        pl.reg_val = ra + W'(1);
                        pl.mem_a   = ra;
                    end
                end
            end
            AM_RIND: begin
                pl.mem_go = 1'b1;
                pl.mem_wr = req_write;
                if (is_two) begin
                    pl.pop_n = 2'd1;
                    pl.mem_a = top0;
                end else begin
                    pl.mem_a = ra;
                end
            end
            AM_STK: begin
                pl.slot_en = 1'b1;
                pl.slot_we = req_write;
                pl.val     = slot_rd;
            end
            AM_CONST: begin
                if (req_write) begin
                    pl.mem_go = 1'b1;
                    pl.mem_wr = 1'b1;
                    pl.mem_a  = const_entry(req_opnd);
                end else begin
                    pl.val = const_entry(req_opnd);
                end
            end
            AM_DISP, AM_IDX: begin
                pl.pop_n  = {1'b0, sec_pop} + {1'b0, base_pop};
                pl.mem_go = 1'b1;
                pl.mem_wr = req_write;
                pl.mem_a  = base_v + sec_v;
            end
            default: pl = '0;
        endcase
    end

    opres_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (fire && stk_ok && pl.reg_we),
        .widx   (pl.reg_idx),
        .wdata  (pl.reg_val),
        .ra_idx (req_opnd),
        .rb_idx (OPND_W'(req_opnd[3:2])),
        .rc_idx (sec_idx),
        .ra     (ra),
        .rb     (rb),
        .rc     (rc)
    );

    opres_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .pop_n      (fire ? pl.pop_n : 2'd0),
        .push       (fire && pl.push),
        .push_data  (req_wdata),
        .slot_en    (fire && pl.slot_en),
        .slot_we    (pl.slot_we),
        .slot_idx   (req_opnd),
        .top0       (top0),
        .top1       (top1),
        .slot_rdata (slot_rd),
        .legal      (stk_ok),
        .err        (stk_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            done      <= 1'b0;
            rd_value  <= '0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            dev_stb   <= 1'b0;
            dev_sel   <= '0;
            dev_data  <= '0;
        end else begin
            done    <= 1'b0;
            dev_stb <= 1'b0;
            mem_req <= 1'b0;
            unique case (phase)
                PH_IDLE: if (fire) begin
                    if (pl.mem_go && stk_ok) begin
                        mem_req   <= 1'b1;
                        mem_we    <= pl.mem_wr;
                        mem_addr  <= pl.mem_a;
                        mem_wdata <= req_wdata;
                        phase     <= pl.mem_wr ? PH_WR : PH_RD;
                    end else begin
                        done <= 1'b1;
                        if (!req_write) rd_value <= stk_ok ? pl.val : '0;
                        if (pl.dev_go) begin
                            dev_stb  <= 1'b1;
                            dev_sel  <= req_opnd;
                            dev_data <= req_wdata;
                        end
                    end
                end
                PH_RD: if (mem_rvalid) begin
                    rd_value <= mem_rdata;
                    done     <= 1'b1;
                    phase    <= PH_IDLE;
                end
                PH_WR: begin
                    done  <= 1'b1;
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R11
    mem_pulse_chk: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req);

    // R11
    mem_busy_chk: assert property (@(posedge clk) disable iff (rst) mem_req |-> busy);

    // R2
    dev_done_chk: assert property (@(posedge clk) disable iff (rst)
        dev_stb |-> (done && !mem_req));

    // R9
    postinc_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && mode == AM_PPI && !req_write && !is_two) |=> (mem_req && !mem_we));

    // R4
    indirect_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && mode == AM_RIND && !is_two) |=> (mem_req && mem_we == $past(req_write)));

endmodule

// File: tb/operand_resolver_tb_top.sv
module operand_resolver_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [3:0]  req_opnd = '0;
    logic [15:0] req_wdata = '0, pc = '0;
    logic        busy, done, stk_err, mem_req, mem_we, dev_stb;
    logic [15:0] rd_value, mem_addr, mem_wdata, dev_data;
    logic [15:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic [3:0]  dev_sel;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;  // 125 MHz

    operand_resolver dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mode(req_mode), .req_opnd(req_opnd), .req_wdata(req_wdata), .pc(pc),
        .busy(busy), .done(done), .rd_value(rd_value), .stk_err(stk_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .dev_stb(dev_stb), .dev_sel(dev_sel), .dev_data(dev_data)
    );

    // memory with one-cycle read latency, 256 words, address wraps
    logic [15:0] bmem [256];
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
            else begin
                mem_rdata  <= bmem[mem_addr[7:0]];
                mem_rvalid <= 1'b1;
            end
        end
    end

    // reference state
    logic [15:0] m_reg [16];
    logic [15:0] m_stk [16];
    logic [15:0] m_mem [256];
    int          m_cnt;
    bit          m_err;

    function automatic logic [15:0] init_word(input int i);
        return 16'(i * 257) ^ 16'h5A00;
    endfunction

    function automatic logic [15:0] m_rd(input int i);
        return (i == 0 || i == 2) ? 16'h0 : m_reg[i];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_reg[i] = '0;
        m_cnt = 0;
        m_err = 0;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic m_mem_op(input logic [15:0] a, input bit wr, input logic [15:0] wd,
                            inout logic [15:0] val, inout int lat);
        if (wr) begin m_mem[a[7:0]] = wd; lat = 2; end
        else    begin val = m_mem[a[7:0]]; lat = 3; end
    endtask

    task automatic model_op(input int m, input int o, input bit wr, input logic [15:0] wd,
                            output logic [15:0] val, output int lat, output bit dev);
        logic [15:0] a, sv, bv;
        int bf, si, need;
        bit sp, bp;
        val = '0; lat = 1; dev = 0;
        case (m)
            0: if (wr) dev = 1; else val = 16'(o);
            1, 7: begin
                if (o == 2) begin
                    if (wr) begin
                        if (m_cnt == 16) m_err = 1;
                        else begin m_stk[m_cnt] = wd; m_cnt++; end
                    end else begin
                        if (m_cnt == 0) m_err = 1;
                        else begin m_cnt--; val = m_stk[m_cnt]; end
                    end
                end else if (m == 1) begin
                    if (wr) begin if (o != 0) m_reg[o] = wd; end
                    else val = m_rd(o);
                end else if (wr) begin
                    a = m_rd(o) - 16'd1;
                    if (o != 0) m_reg[o] = a;
                    m_mem_op(a, 1, wd, val, lat);
                end else begin
                    a = m_rd(o);
                    if (o != 0) m_reg[o] = a + 16'd1;
                    m_mem_op(a, 0, wd, val, lat);
                end
            end
            2: begin
                if (o == 2) begin
                    if (m_cnt == 0) m_err = 1;
                    else begin m_cnt--; m_mem_op(m_stk[m_cnt], wr, wd, val, lat); end
                end else m_mem_op(m_rd(o), wr, wd, val, lat);
            end
            3: begin
                if (o >= m_cnt) m_err = 1;
                else if (wr) m_stk[m_cnt-1-o] = wd;
                else val = m_stk[m_cnt-1-o];
            end
            4: begin
                a = 16'h0100 + 16'(o * 16);
                if (wr) m_mem_op(a, 1, wd, val, lat);
                else val = a;
            end
            default: begin  // 5 displacement, 6 indexed
                bf = o >> 2;
                sp = (m == 5) ? ((o & 3) == 2) : ((o & 3) == 0);
                si = (m == 5) ? (o & 3) : (o & 3) + 2;
                bp = (bf == 2);
                need = int'(sp) + int'(bp);
                if (m_cnt < need) m_err = 1;
                else begin
                    if (sp) begin m_cnt--; sv = m_stk[m_cnt]; end else sv = m_rd(si);
                    if (bp) begin m_cnt--; bv = m_stk[m_cnt]; end
                    else bv = (bf == 0) ? pc : m_rd(bf);
                    m_mem_op(bv + sv, wr, wd, val, lat);
                end
            end
        endcase
    endtask

    task automatic do_op(input int m, input int o, input bit wr, input logic [15:0] wd,
                         input string tag, output logic [15:0] act);
        logic [15:0] ev;
        int elat, lat;
        bit edev;
        model_op(m, o, wr, wd, ev, elat, edev);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_mode = 3'(m); req_opnd = 4'(o); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin @(negedge clk); lat++; end
        act = rd_value;
        if (!wr) check({tag, " value"}, rd_value, ev);
        check("R11 latency", 16'(lat), 16'(elat));
        if (m == 0 && wr) begin
            check("R2 dev_stb", 16'(dev_stb), 16'd1);
            check("R2 dev_sel", 16'(dev_sel), 16'(o));
            check("R2 dev_data", dev_data, wd);
        end else if (dev_stb) check("R2 stray dev_stb", 16'(dev_stb), 16'd0);
        check("R10 stk_err", 16'(stk_err), 16'(m_err));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        check("R1 busy", 16'(busy), 16'd0);
        check("R1 done", 16'(done), 16'd0);
        check("R1 stk_err", 16'(stk_err), 16'd0);
        check("R1 mem_req", 16'(mem_req), 16'd0);
        check("R1 dev_stb", 16'(dev_stb), 16'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 256; i++) begin
            bmem[i]  = init_word(i);
            m_mem[i] = init_word(i);
        end
        void'($urandom(32'd2718));
        do_reset();
        do_op(1, 5, 0, 0, "R1 reg5 after reset", v);   check("R1 reg5 zero", v, 16'h0);

        // R3 register direct, zero register
        do_op(1, 5, 1, 16'h1234, "R3", v);
        do_op(1, 5, 0, 0, "R3", v);                    check("R3 reg5", v, 16'h1234);
        do_op(1, 0, 1, 16'hFFFF, "R3", v);
        do_op(1, 0, 0, 0, "R3", v);                    check("R3 reg0 zero", v, 16'h0);

        // R2 immediate
        do_op(0, 9, 0, 0, "R2", v);                    check("R2 imm read", v, 16'h0009);
        do_op(0, 6, 1, 16'hBEEF, "R2", v);

        // R5 stack slots, R3 alias
        do_op(1, 2, 1, 16'h0011, "R3", v);
        do_op(1, 2, 1, 16'h0022, "R3", v);
        do_op(3, 0, 0, 0, "R5", v);                    check("R5 slot0", v, 16'h0022);
        do_op(3, 1, 0, 0, "R5", v);                    check("R5 slot1", v, 16'h0011);
        do_op(3, 1, 1, 16'h0033, "R5", v);
        do_op(1, 2, 0, 0, "R3", v);                    check("R3 pop1", v, 16'h0022);
        do_op(1, 2, 0, 0, "R3", v);                    check("R3 pop2", v, 16'h0033);

        // R6 constants, R4 indirect
        do_op(4, 3, 0, 0, "R6", v);                    check("R6 const3", v, 16'h0130);
        do_op(4, 1, 1, 16'hCAFE, "R6", v);
        do_op(1, 6, 1, 16'h0110, "R4", v);
        do_op(2, 6, 0, 0, "R4", v);                    check("R6 const store", v, 16'hCAFE);
        do_op(1, 2, 1, 16'h0044, "R4", v);
        do_op(2, 2, 1, 16'h7777, "R4", v);
        do_op(1, 7, 1, 16'h0044, "R4", v);
        do_op(2, 7, 0, 0, "R4", v);                    check("R4 popped addr", v, 16'h7777);

        // R7 displacement: pc base, both fields popped
        pc = 16'h0050;
        do_op(1, 1, 1, 16'h0003, "R7", v);
        do_op(5, 1, 1, 16'h5151, "R7", v);
        do_op(1, 4, 1, 16'h0053, "R7", v);
        do_op(2, 4, 0, 0, "R7", v);                    check("R7 pc+reg", v, 16'h5151);
        do_op(1, 2, 1, 16'h0010, "R7", v);
        do_op(1, 2, 1, 16'h0005, "R7", v);
        do_op(5, 10, 1, 16'h1515, "R7", v);
        do_op(1, 4, 1, 16'h0015, "R7", v);
        do_op(2, 4, 0, 0, "R7", v);                    check("R7 two pops", v, 16'h1515);

        // R8 indexed
        do_op(1, 3, 1, 16'h0020, "R8", v);
        do_op(6, 5, 1, 16'h2323, "R8", v);
        do_op(1, 4, 1, 16'h0023, "R8", v);
        do_op(2, 4, 0, 0, "R8", v);                    check("R8 reg1+reg3", v, 16'h2323);
        do_op(1, 2, 1, 16'h0007, "R8", v);
        do_op(6, 0, 1, 16'h5757, "R8", v);
        do_op(1, 4, 1, 16'h0057, "R8", v);
        do_op(2, 4, 0, 0, "R8", v);                    check("R8 pc+pop", v, 16'h5757);

        // R9 predecrement / postincrement
        do_op(1, 7, 1, 16'h0020, "R9", v);
        do_op(7, 7, 1, 16'h9999, "R9", v);
        do_op(1, 7, 0, 0, "R9", v);                    check("R9 predec reg", v, 16'h001F);
        do_op(7, 7, 0, 0, "R9", v);                    check("R9 postinc data", v, 16'h9999);
        do_op(1, 7, 0, 0, "R9", v);                    check("R9 postinc reg", v, 16'h0020);

        // R10 underflow, then overflow
        do_op(1, 2, 0, 0, "R10 underflow", v);         check("R10 underflow val", v, 16'h0);
        check("R10 err set", 16'(stk_err), 16'd1);
        do_reset();
        for (int i = 0; i < 16; i++) do_op(1, 2, 1, 16'h0A00 + 16'(i), "R10 fill", v);
        check("R10 no err when full", 16'(stk_err), 16'd0);
        do_op(1, 2, 1, 16'hDEAD, "R10 overflow", v);
        check("R10 err on overflow", 16'(stk_err), 16'd1);
        do_op(3, 0, 0, 0, "R10", v);                   check("R10 top kept", v, 16'h0A0F);
        do_op(3, 15, 0, 0, "R5", v);                   check("R5 bottom slot", v, 16'h0A00);

        // random mix
        do_reset();
        for (int n = 0; n < 600; n++) begin
            pc = 16'($urandom);
            do_op(int'($urandom % 8), int'($urandom % 16), bit'($urandom % 2),
                  16'($urandom), "R3-R9 random", v);
            if (m_err) do_reset();
        end

        for (int i = 0; i < 256; i++) begin
            if (bmem[i] !== m_mem[i]) check("R4 memory image", bmem[i], m_mem[i]);
        end
        total++;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule